// File: doc/BRIEF.md
# Twisted-Pair Link Integrity and Jabber Supervisor

This block watches one 10BASE-T transceiver port. While the transmitter is quiet it sends a short positive link test pulse at a fixed interval. It watches the receive side for data or for link pulses of either polarity. If nothing arrives for a whole timeout window, it declares the link failed. To bring the link back up, it needs a run of consecutive link pulses of one polarity.

A jabber guard is also included. It cuts the transmit enable when a transmission runs too long. It gives the enable back only after a long quiet interval. The block builds the collision indication for the MAC from three sources: the real collision input, which is masked while the link is down; the jabber state; and a short signal-quality-test burst after each transmission. It also drives a status LED.

All times are counted in clocks of the 20 MHz port clock. The defaults give a 100 ns pulse, a 13 ms pulse interval, a 105 ms link timeout, a 26.2 ms jabber limit, a 420 ms re-enable interval and a 10 Hz blink.

Top module: `tpl_link_supervisor`

## Requirements
- R1: While `tx_active` is low and the link test is enabled, `link_pulse_out` is high for exactly PULSE_W clocks out of every PERIOD clocks. While `tx_active` is high it stays low, and the interval count restarts from zero.
- R2: In link-good, if PERIOD-independent TIMEOUT consecutive clocks pass with none of `rx_data_activity`, `rx_pos_pulse` or `rx_neg_pulse`, `link_good` falls on the TIMEOUT-th clock. Any one of these inputs restarts the window.
- R3: In link-fail, `link_good` rises on the clock of the POS_NEED-th consecutive positive pulse (default 4) or the NEG_NEED-th consecutive negative pulse (default 8). Receive data alone does not restore the link.
- R4: A pulse of the other polarity restarts the consecutive count at one. An expired timeout clears the count. Both polarities in the same clock clear it.
- R5: `collision_in` reaches `collision_out` only while `link_good` is high.
- R6: When `tx_active` stays high for JAB_LIMIT consecutive clocks, `tx_enable` falls on that clock. `collision_out` stays high for as long as `tx_enable` is low.
- R7: After a cut-off, `tx_enable` returns after QUIET consecutive clocks with `tx_active` low. Any clock with `tx_active` high restarts that count.
- R8: When `tx_active` falls and no cut-off is in force, `collision_out` is high for SQE_LEN clocks, starting on the clock after the fall.
- R9: While `link_test_en_n` is high, `link_good` reads 1, no link pulses are sent, and no timeout occurs. When it returns low, the timeout window starts from zero.
- R10: With no transmit or receive activity, `led` is steadily 0 in link-good and steadily 1 in link-fail.
- R11: While `tx_active` or `rx_data_activity` is high, `led` toggles every BLINK_HALF clocks and starts at 0. If `collision_in` has been high for STUCK clocks in a row, `led` is 1 whatever else holds.
- R12: After reset the block is in link-fail with `tx_enable` high, `collision_out` low and `led` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (20 MHz nominal) |
| rst_n | input | 1 | Active-low reset |
| tx_active | input | 1 | Transmitter is sending |
| rx_data_activity | input | 1 | Receive data / carrier present |
| rx_pos_pulse | input | 1 | Positive link pulse seen (one clock) |
| rx_neg_pulse | input | 1 | Negative link pulse seen (one clock) |
| collision_in | input | 1 | Raw collision from the line receiver |
| link_test_en_n | input | 1 | Low enables the link test; high disables it |
| link_pulse_out | output | 1 | Link test pulse to the line driver |
| link_good | output | 1 | Link state, 1 = good |
| tx_enable | output | 1 | Transmit permitted (0 while jabbering) |
| collision_out | output | 1 | Collision indication to the MAC |
| led | output | 1 | Status LED drive |

## Verification
The hardest state to reach from the ports is a partial consecutive-pulse run in link-fail. The run has to be cut short by an opposite-polarity pulse or by an expired timeout, and the outcome depends on the exact history of polarities. The bench first forces link-fail by waiting out the timeout. It then feeds seeded random sequences of positive and negative pulses, spaced a few clocks apart, and after every pulse compares `link_good` with a bench model of the run count. Directed sequences cover the threshold edges: three, seven and mixed runs, and a run interrupted by a timeout. Small timing parameters keep the jabber and re-enable windows reachable within the run.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pulse_pol_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/tpl_pulse_gen.sv
module tpl_pulse_gen #(
    parameter int PULSE_W = 2,
    parameter int PERIOD  = 260000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic test_off,
    output logic pulse_out
);
    localparam int CW = $clog2(PERIOD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_active || test_off) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(PERIOD - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_out = !tx_active && !test_off && (st_q.cnt >= CW'(PERIOD - PULSE_W));
endmodule

// File: rtl/tpl_link_mon.sv
module tpl_link_mon
    import tpl_pkg::*;
#(
    parameter int TIMEOUT  = 2100000,
    parameter int POS_NEED = 4,
    parameter int NEG_NEED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_off,
    input  logic rx_data,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic link_good
);
    localparam int TW = $clog2(TIMEOUT);
    localparam int SW = $clog2(max2(POS_NEED, NEG_NEED) + 1);

    typedef struct packed {
        logic          good;
        logic [TW-1:0] to_cnt;
        logic [SW-1:0] streak;
        pulse_pol_e    pol;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    any_act;
    logic    expired;
    logic [SW-1:0] run_next;

    always_comb begin
        st_d     = st_q;
        any_act  = rx_data || rx_pos || rx_neg;
        expired  = 1'b0;
        run_next = '0;
        if (test_off) begin
            st_d.good   = 1'b1;
            st_d.to_cnt = '0;
            st_d.streak = '0;
        end else begin
            if (any_act) begin
                st_d.to_cnt = '0;
            end else if (st_q.to_cnt == TW'(TIMEOUT - 1)) begin
                st_d.to_cnt = '0;
                expired     = 1'b1;
            end else begin
                st_d.to_cnt = st_q.to_cnt + 1'b1;
            end

            if (expired) begin
                st_d.good   = 1'b0;
                st_d.streak = '0;
            end else if (!st_q.good) begin
                if (rx_pos && rx_neg) begin
                    st_d.streak = '0;
                end else if (rx_pos) begin
                    run_next = (st_q.pol == POL_POS) ? st_q.streak + 1'b1 : SW'(1);
                    st_d.pol = POL_POS;
                    if (run_next == SW'(POS_NEED)) begin
                        st_d.good   = 1'b1;
                        st_d.streak = '0;
                    end else begin
                        st_d.streak = run_next;
                    end
                end else if (rx_neg) begin
                    run_next = (st_q.pol == POL_NEG) ? st_q.streak + 1'b1 : SW'(1);
                    st_d.pol = POL_NEG;
                    if (run_next == SW'(NEG_NEED)) begin
                        st_d.good   = 1'b1;
                        st_d.streak = '0;
                    end else begin
                        st_d.streak = run_next;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.good   <= 1'b0;
            st_q.to_cnt <= '0;
            st_q.streak <= '0;
            st_q.pol    <= POL_POS;
        end else begin
            st_q <= st_d;
        end
    end

    assign link_good = st_q.good;
endmodule

// File: rtl/tpl_jabber.sv
module tpl_jabber #(
    parameter int JAB_LIMIT = 524000,
    parameter int QUIET     = 8400000,
    parameter int SQE_LEN   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic tx_enable,
    output logic jab_active,
    output logic sqe_active
);
    localparam int JW = $clog2(JAB_LIMIT);
    localparam int QW = $clog2(QUIET);
    localparam int EW = $clog2(SQE_LEN + 1);

    typedef struct packed {
        logic          jab;
        logic [JW-1:0] run;
        logic [QW-1:0] quiet;
        logic          tx_prev;
        logic [EW-1:0] sqe;
    } jab_st_t;

    jab_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.tx_prev = tx_active;
        if (st_q.sqe != '0) st_d.sqe = st_q.sqe - 1'b1;
        if (!st_q.jab) begin
            st_d.quiet = '0;
            if (tx_active) begin
                if (st_q.run == JW'(JAB_LIMIT - 1)) begin
                    st_d.jab = 1'b1;
                    st_d.run = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
                if (st_q.tx_prev) st_d.sqe = EW'(SQE_LEN);
            end
        end else begin
            st_d.run = '0;
            if (tx_active) begin
                st_d.quiet = '0;
            end else if (st_q.quiet == QW'(QUIET - 1)) begin
                st_d.jab   = 1'b0;
                st_d.quiet = '0;
            end else begin
                st_d.quiet = st_q.quiet + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_enable  = !st_q.jab;
    assign jab_active = st_q.jab;
    assign sqe_active = (st_q.sqe != '0);
endmodule

// File: rtl/tpl_link_supervisor.sv
module tpl_link_supervisor #(
    parameter int PULSE_W    = 2,
    parameter int PERIOD     = 260000,
    parameter int TIMEOUT    = 2100000,
    parameter int POS_NEED   = 4,
    parameter int NEG_NEED   = 8,
    parameter int JAB_LIMIT  = 524000,
    parameter int QUIET      = 8400000,
    parameter int SQE_LEN    = 20,
    parameter int BLINK_HALF = 1000000,
    parameter int STUCK      = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic rx_data_activity,
    input  logic rx_pos_pulse,
    input  logic rx_neg_pulse,
    input  logic collision_in,
    input  logic link_test_en_n,
    output logic link_pulse_out,
    output logic link_good,
    output logic tx_enable,
    output logic collision_out,
    output logic led
);
    localparam int BW = $clog2(BLINK_HALF);
    localparam int CW = $clog2(STUCK + 1);

    logic jab_active;
    logic sqe_active;
    logic activity;

    tpl_pulse_gen #(.PULSE_W(PULSE_W), .PERIOD(PERIOD)) pulse_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .test_off  (link_test_en_n),
        .pulse_out (link_pulse_out)
    );

    tpl_link_mon #(.TIMEOUT(TIMEOUT), .POS_NEED(POS_NEED), .NEG_NEED(NEG_NEED)) mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_off  (link_test_en_n),
        .rx_data   (rx_data_activity),
        .rx_pos    (rx_pos_pulse),
        .rx_neg    (rx_neg_pulse),
        .link_good (link_good)
    );

    tpl_jabber #(.JAB_LIMIT(JAB_LIMIT), .QUIET(QUIET), .SQE_LEN(SQE_LEN)) jab_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_active  (tx_active),
        .tx_enable  (tx_enable),
        .jab_active (jab_active),
        .sqe_active (sqe_active)
    );

    typedef struct packed {
        logic [BW-1:0] blink_cnt;
        logic          phase;
        logic [CW-1:0] coll_run;
    } led_st_t;

    led_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        activity = tx_active || rx_data_activity;
        if (activity) begin
            if (st_q.blink_cnt == BW'(BLINK_HALF - 1)) begin
                st_d.blink_cnt = '0;
                st_d.phase     = !st_q.phase;
            end else begin
                st_d.blink_cnt = st_q.blink_cnt + 1'b1;
            end
        end else begin
            st_d.blink_cnt = '0;
            st_d.phase     = 1'b0;
        end
        if (!collision_in) begin
            st_d.coll_run = '0;
        end else if (st_q.coll_run != CW'(STUCK)) begin
            st_d.coll_run = st_q.coll_run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign collision_out = (collision_in && link_good) || jab_active || sqe_active;
    assign led = (st_q.coll_run == CW'(STUCK)) ? 1'b1 :
                 activity                      ? st_q.phase : !link_good;
endmodule

// File: rtl/tpl_link_supervisor_chk.sv
module tpl_link_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic rx_data_activity,
    input logic rx_pos_pulse,
    input logic rx_neg_pulse,
    input logic collision_in,
    input logic link_test_en_n,
    input logic link_pulse_out,
    input logic link_good,
    input logic tx_enable,
    input logic collision_out,
    input logic led
);
    // R1
    pulse_quiet_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !link_pulse_out);
    // R9
    pulse_quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_test_en_n |-> !link_pulse_out);
    // R9
    held_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_test_en_n |=> link_good);
    // R3
    good_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_good) |-> $past(rx_pos_pulse || rx_neg_pulse || link_test_en_n));
    // R2
    good_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_good) |-> !$past(rx_data_activity || rx_pos_pulse || rx_neg_pulse || link_test_en_n));
    // R5
    coll_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collision_in && link_good) |-> collision_out);
    // R6
    jab_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> collision_out);
    // R6
    jab_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_enable) |-> $past(tx_active));
    // R7
    jab_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |-> !$past(tx_active));
    // R10
    led_good_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_good && !tx_active && !rx_data_activity && !collision_in && $past(!collision_in)) |-> !led);
endmodule

bind tpl_link_supervisor tpl_link_supervisor_chk chk_i (.*);

// File: tb/tpl_link_supervisor_tb_top.sv
module tpl_link_supervisor_tb_top;
    localparam int PW    = 2;
    localparam int PER   = 40;
    localparam int TO    = 300;
    localparam int JAB   = 50;
    localparam int QT    = 120;
    localparam int SQE   = 4;
    localparam int BLK   = 10;
    localparam int STK   = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0, rx_data_activity = 1'b0, rx_pos_pulse = 1'b0, rx_neg_pulse = 1'b0;
    logic collision_in = 1'b0, link_test_en_n = 1'b0;
    logic link_pulse_out, link_good, tx_enable, collision_out, led;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model of the consecutive-pulse run
    bit m_good;
    int m_cnt;
    bit m_neg;

    always #5 clk = ~clk;

    tpl_link_supervisor #(
        .PULSE_W(PW), .PERIOD(PER), .TIMEOUT(TO), .POS_NEED(4), .NEG_NEED(8),
        .JAB_LIMIT(JAB), .QUIET(QT), .SQE_LEN(SQE), .BLINK_HALF(BLK), .STUCK(STK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_data_activity(rx_data_activity),
        .rx_pos_pulse(rx_pos_pulse), .rx_neg_pulse(rx_neg_pulse), .collision_in(collision_in),
        .link_test_en_n(link_test_en_n), .link_pulse_out(link_pulse_out), .link_good(link_good),
        .tx_enable(tx_enable), .collision_out(collision_out), .led(led)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_pulse(input bit neg);
        if (!m_good) begin
            if (m_cnt > 0 && m_neg == neg) m_cnt++;
            else m_cnt = 1;
            m_neg = neg;
            if (m_cnt == (neg ? 8 : 4)) begin
                m_good = 1'b1;
                m_cnt  = 0;
            end
        end
    endfunction

    // send one link pulse; returns link_good in the clock after it
    task automatic send_pulse(input bit neg, output bit lg);
        if (neg) rx_neg_pulse = 1'b1; else rx_pos_pulse = 1'b1;
        step(1);
        lg = link_good;
        rx_pos_pulse = 1'b0;
        rx_neg_pulse = 1'b0;
        step(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit lg;
        int r1, r2, w, cnt, tog;
        bit prev, v;
        void'($urandom(32'd20240611));

        step(3);
        // R12 reset state
        chk(link_good == 1'b0, "R12 link_good", link_good, 0);
        chk(tx_enable == 1'b1, "R12 tx_enable", tx_enable, 1);
        chk(collision_out == 1'b0, "R12 collision_out", collision_out, 0);
        chk(led == 1'b1, "R12 led", led, 1);
        rst_n = 1'b1;

        // R1 pulse width and interval
        r1 = -1; r2 = -1; w = 0; prev = 1'b0;
        for (int i = 0; i < 130; i++) begin
            step(1);
            v = link_pulse_out;
            if (v && !prev) begin
                if (r1 < 0) r1 = i;
                else if (r2 < 0) r2 = i;
            end
            if (v && r1 >= 0 && r2 < 0) w++;
            prev = v;
        end
        chk(w == PW, "R1 pulse width", w, PW);
        chk(r2 - r1 == PER, "R1 pulse interval", r2 - r1, PER);

        // R1 no pulses while transmitting
        tx_active = 1'b1;
        cnt = 0;
        for (int i = 0; i < 45; i++) begin
            step(1);
            if (link_pulse_out) cnt++;
        end
        chk(cnt == 0, "R1 pulses during tx", cnt, 0);
        // R8 signal quality burst after tx
        tx_active = 1'b0;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (collision_out) cnt++;
        end
        chk(cnt == SQE, "R8 sqe length", cnt, SQE);

        // R5 collision masked in link-fail
        collision_in = 1'b1;
        step(1);
        chk(collision_out == 1'b0, "R5 masked in fail", collision_out, 0);
        collision_in = 1'b0;
        step(1);

        // R10 fail idle led
        chk(led == 1'b1, "R10 led fail", led, 1);

        // R3 recovery with positive pulses
        for (int i = 0; i < 3; i++) begin
            send_pulse(1'b0, lg);
            chk(lg == 1'b0, "R3 pos below threshold", lg, 0);
        end
        send_pulse(1'b0, lg);
        chk(lg == 1'b1, "R3 fourth positive", lg, 1);

        // R5 collision passes in link-good
        collision_in = 1'b1;
        step(1);
        chk(collision_out == 1'b1, "R5 passes in good", collision_out, 1);
        collision_in = 1'b0;
        step(1);
        // R10 good idle led
        chk(led == 1'b0, "R10 led good", led, 0);

        // R11 blink during receive activity
        rx_data_activity = 1'b1;
        tog = 0; prev = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (i > 0 && led != prev) tog++;
            prev = led;
        end
        chk(tog == 3 || tog == 4, "R11 blink toggles", tog, 4);
        rx_data_activity = 1'b0;

        // R11 stuck collision forces led high
        collision_in = 1'b1;
        step(STK + 5);
        chk(led == 1'b1, "R11 stuck collision led", led, 1);
        collision_in = 1'b0;
        step(1);
        chk(led == 1'b0, "R11 led after stuck clears", led, 0);

        // R2 timeout exact
        rx_data_activity = 1'b1;
        step(1);
        rx_data_activity = 1'b0;
        step(TO - 1);
        chk(link_good == 1'b1, "R2 before timeout", link_good, 1);
        step(1);
        chk(link_good == 1'b0, "R2 at timeout", link_good, 0);

        // R3 negative recovery: seven is not enough, eight is
        for (int i = 0; i < 7; i++) send_pulse(1'b1, lg);
        chk(lg == 1'b0, "R3 seven negative", lg, 0);
        send_pulse(1'b1, lg);
        chk(lg == 1'b1, "R3 eighth negative", lg, 1);

        // R2 reload keeps link up
        for (int i = 0; i < 4; i++) begin
            step(200);
            rx_data_activity = 1'b1;
            step(1);
            rx_data_activity = 1'b0;
        end
        chk(link_good == 1'b1, "R2 reload holds good", link_good, 1);
        step(TO + 2);
        chk(link_good == 1'b0, "R2 drop after reload", link_good, 0);

        // R4 opposite polarity restarts the run
        for (int i = 0; i < 3; i++) send_pulse(1'b0, lg);
        send_pulse(1'b1, lg);
        for (int i = 0; i < 3; i++) send_pulse(1'b0, lg);
        chk(lg == 1'b0, "R4 run broken by negative", lg, 0);
        send_pulse(1'b0, lg);
        chk(lg == 1'b1, "R4 fresh run completes", lg, 1);
        step(TO + 2);

        // R4 timeout clears the run
        for (int i = 0; i < 3; i++) send_pulse(1'b0, lg);
        step(TO + 2);
        send_pulse(1'b0, lg);
        chk(lg == 1'b0, "R4 run cleared by timeout", lg, 0);
        // R4 both polarities at once clear the run
        send_pulse(1'b0, lg);
        send_pulse(1'b0, lg);
        rx_pos_pulse = 1'b1; rx_neg_pulse = 1'b1;
        step(1);
        rx_pos_pulse = 1'b0; rx_neg_pulse = 1'b0;
        step(2);
        send_pulse(1'b0, lg);
        chk(lg == 1'b0, "R4 simultaneous clears", lg, 0);

        // R6 jabber cut-off
        tx_active = 1'b1;
        step(JAB - 1);
        chk(tx_enable == 1'b1, "R6 before limit", tx_enable, 1);
        step(1);
        chk(tx_enable == 1'b0, "R6 at limit", tx_enable, 0);
        chk(collision_out == 1'b1, "R6 collision while jabbering", collision_out, 1);
        // R7 re-enable with restart
        tx_active = 1'b0;
        step(100);
        tx_active = 1'b1;
        step(1);
        tx_active = 1'b0;
        step(QT - 1);
        chk(tx_enable == 1'b0, "R7 restarted quiet", tx_enable, 0);
        step(1);
        chk(tx_enable == 1'b1, "R7 released", tx_enable, 1);
        chk(collision_out == 1'b0, "R8 no burst after cut-off", collision_out, 0);

        // R9 link test disabled
        link_test_en_n = 1'b1;
        step(1);
        chk(link_good == 1'b1, "R9 forced good", link_good, 1);
        cnt = 0;
        for (int i = 0; i < 400; i++) begin
            step(1);
            if (link_pulse_out || !link_good) cnt++;
        end
        chk(cnt == 0, "R9 no pulses or drop", cnt, 0);
        link_test_en_n = 1'b0;
        step(TO - 1);
        chk(link_good == 1'b1, "R9 fresh window", link_good, 1);
        step(1);
        chk(link_good == 1'b0, "R9 timeout after enable", link_good, 0);

        // R3 R4 random pulse runs against the model
        for (int t = 0; t < 20; t++) begin
            step(TO + 5);
            m_good = 1'b0; m_cnt = 0; m_neg = 1'b0;
            for (int p = 0; p < 12; p++) begin
                v = ($urandom_range(0, 99) < ((t % 2 == 0) ? 25 : 80));
                model_pulse(v);
                send_pulse(v, lg);
                chk(lg == m_good, "R3 random run", lg, m_good);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule